// File: doc/BRIEF.md
# Serial Port Pin Polarity and Direction Control

This block sits between the four timing pins of a synchronous serial port (one clock and one frame-sync pin for transmit, the same pair for receive) and the port's internal shifters. Each pin has a direction bit. When the bit is 1, an internal generator drives the pin. When the bit is 0, the pin is an input from outside. Each pin also has a polarity bit. The polarity bit inverts the signal on whichever side of the pin faces outward, so inside the block clocks keep fixed active edges and frame-syncs are always active high.

Everything runs on a fast system clock. External pins pass through a synchroniser. Each channel's serial clock is converted into single-cycle enables for its rising and falling edges. The transmitter shifts on rising enables and the receiver samples on falling enables. External frame-syncs are captured on the internal falling edge. Generated frame-syncs are registered on the internal rising edge before they reach the pin. Channel index 0 is transmit and index 1 is receive on every vector port.

Top module: `sp_pin_ctrl`

## Requirements
- R1: Each output-enable (`clk_oe_o[c]`, `fs_oe_o[c]`) equals its direction bit: 1 means the pin is driven, 0 means the pin is an input and its driver is off.
- R2: With `clk_dir_i[c]`=1, the internal clock of channel c is `gen_clk_i`, and `clk_pin_o[c]` equals `gen_clk_i` XOR `clk_pol_i[c]` in the same cycle.
- R3: With `clk_dir_i[c]`=0, the internal clock is the synchronised pin XOR `clk_pol_i[c]`. A pin change made just after edge k shows up as a one-cycle edge enable in the cycle after edge k+SYNC_STAGES (default: after edge k+2).
- R4: `rise_en_o[c]` pulses for one cycle on each 0-to-1 transition of the internal clock. `fall_en_o[c]` pulses for one cycle on each 1-to-0 transition. The two are never high together.
- R5: With `fs_dir_i[c]`=0, `fs_int_o[c]` takes the synchronised frame-sync pin XOR `fs_pol_i[c]` at the system edge that ends a `fall_en_o[c]` cycle. A rising internal clock edge leaves it unchanged.
- R6: With `fs_dir_i[c]`=1, `gen_fs_i[c]` (active high) is registered at the edge that ends a `rise_en_o[c]` cycle. `fs_int_o[c]` shows the registered value and `fs_pin_o[c]` shows it XOR `fs_pol_i[c]`. Between rising enables, changes on `gen_fs_i[c]` do not reach either output.
- R7: After reset all edge enables and `fs_int_o` are 0. The edge enables stay suppressed for the first SYNC_STAGES+1 cycles after reset is released, so the synchroniser filling up produces no spurious edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_dir_i | input | 2 | Clock pin direction, 1 = output |
| clk_pol_i | input | 2 | Clock pin inversion |
| fs_dir_i | input | 2 | Frame-sync pin direction, 1 = output |
| fs_pol_i | input | 2 | Frame-sync pin inversion |
| clk_pin_i | input | 2 | Clock pin input level |
| fs_pin_i | input | 2 | Frame-sync pin input level |
| gen_clk_i | input | 1 | Internal generated serial clock |
| gen_fs_i | input | 2 | Internal generated frame-sync, active high |
| clk_pin_o | output | 2 | Clock pin output level |
| clk_oe_o | output | 2 | Clock pin driver enable |
| fs_pin_o | output | 2 | Frame-sync pin output level |
| fs_oe_o | output | 2 | Frame-sync pin driver enable |
| rise_en_o | output | 2 | Internal rising-edge enable |
| fall_en_o | output | 2 | Internal falling-edge enable |
| fs_int_o | output | 2 | Internal active-high frame-sync |

## Verification
The assertions run on every cycle. They check that rising and falling enables are exclusive single-cycle pulses, that the warm-up window suppresses them, and that neither frame-sync register moves except at its own edge enable. An input frame-sync register must also capture exactly the corrected pin value.

Only the bench scenarios can show:
- the synchroniser latency counted from a pin change;
- the inversion applied in each direction and polarity combination;
- the pin levels and driver enables seen from outside.

// File: rtl/sp_pin_pkg.sv
package sp_pin_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_TX  = 0;
  localparam int unsigned CH_RX  = 1;

  typedef struct packed {
    logic clk_dir;
    logic clk_pol;
    logic fs_dir;
    logic fs_pol;
  } pin_cfg_t;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sp_pin_chan.sv
module sp_pin_chan
  import sp_pin_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  pin_cfg_t cfg_i,
  input  logic     ready_i,
  input  logic     clk_pin_i,
  input  logic     fs_pin_i,
  input  logic     gen_clk_i,
  input  logic     gen_fs_i,
  output logic     clk_pin_o,
  output logic     clk_oe_o,
  output logic     fs_pin_o,
  output logic     fs_oe_o,
  output logic     rise_en_o,
  output logic     fall_en_o,
  output logic     fs_int_o
);
  logic [1:0] pin_sync;
  logic       clk_ext, fs_ext;
  logic       clk_int, clk_prev_q;
  logic       fs_in_q, fs_out_q;

  sp_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({fs_pin_i, clk_pin_i}),
    .q_o    (pin_sync)
  );

  // polarity applied on the outward side only
  assign clk_ext = pin_sync[0] ^ cfg_i.clk_pol;
  assign fs_ext  = pin_sync[1] ^ cfg_i.fs_pol;
  assign clk_int = cfg_i.clk_dir ? gen_clk_i : clk_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_prev_q <= 1'b0;
    else         clk_prev_q <= clk_int;
  end

  assign rise_en_o = ready_i &  clk_int & ~clk_prev_q;
  assign fall_en_o = ready_i & ~clk_int &  clk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_in_q  <= 1'b0;
      fs_out_q <= 1'b0;
    end else begin
      if (fall_en_o) fs_in_q  <= fs_ext;
      if (rise_en_o) fs_out_q <= gen_fs_i;
    end
  end

  assign fs_int_o  = cfg_i.fs_dir ? fs_out_q : fs_in_q;
  assign clk_pin_o = gen_clk_i ^ cfg_i.clk_pol;
  assign clk_oe_o  = cfg_i.clk_dir;
  assign fs_pin_o  = fs_out_q ^ cfg_i.fs_pol;
  assign fs_oe_o   = cfg_i.fs_dir;

  a_r4_edges_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_en_o && fall_en_o));
  a_r4_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_en_o |=> !rise_en_o);
  a_r4_fall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_en_o |=> !fall_en_o);
  a_r5_fs_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_en_o |=> $stable(fs_in_q));
  a_r5_fs_in_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_en_o |=> fs_in_q == $past(pin_sync[1] ^ cfg_i.fs_pol));
  a_r6_fs_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_en_o |=> $stable(fs_out_q));
endmodule

// File: rtl/sp_pin_ctrl.sv
module sp_pin_ctrl
  import sp_pin_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] clk_dir_i,
  input  logic [NUM_CH-1:0] clk_pol_i,
  input  logic [NUM_CH-1:0] fs_dir_i,
  input  logic [NUM_CH-1:0] fs_pol_i,
  input  logic [NUM_CH-1:0] clk_pin_i,
  input  logic [NUM_CH-1:0] fs_pin_i,
  input  logic              gen_clk_i,
  input  logic [NUM_CH-1:0] gen_fs_i,
  output logic [NUM_CH-1:0] clk_pin_o,
  output logic [NUM_CH-1:0] clk_oe_o,
  output logic [NUM_CH-1:0] fs_pin_o,
  output logic [NUM_CH-1:0] fs_oe_o,
  output logic [NUM_CH-1:0] rise_en_o,
  output logic [NUM_CH-1:0] fall_en_o,
  output logic [NUM_CH-1:0] fs_int_o
);
  localparam int unsigned WARM   = SYNC_STAGES + 1;
  localparam int unsigned WARM_W = $clog2(WARM + 1);

  logic [WARM_W-1:0] warm_q;
  logic              ready;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    warm_q <= '0;
    else if (warm_q != WARM_W'(WARM)) warm_q <= warm_q + 1'b1;
  end
  assign ready = (warm_q == WARM_W'(WARM));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pin_cfg_t cfg;
    assign cfg = '{clk_dir: clk_dir_i[c], clk_pol: clk_pol_i[c],
                   fs_dir: fs_dir_i[c], fs_pol: fs_pol_i[c]};

    sp_pin_chan #(.SYNC_STAGES(SYNC_STAGES)) i_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cfg_i     (cfg),
      .ready_i   (ready),
      .clk_pin_i (clk_pin_i[c]),
      .fs_pin_i  (fs_pin_i[c]),
      .gen_clk_i (gen_clk_i),
      .gen_fs_i  (gen_fs_i[c]),
      .clk_pin_o (clk_pin_o[c]),
      .clk_oe_o  (clk_oe_o[c]),
      .fs_pin_o  (fs_pin_o[c]),
      .fs_oe_o   (fs_oe_o[c]),
      .rise_en_o (rise_en_o[c]),
      .fall_en_o (fall_en_o[c]),
      .fs_int_o  (fs_int_o[c])
    );
  end

  a_r7_warm_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready |-> (rise_en_o == '0 && fall_en_o == '0));
  a_r7_warm_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ready) |-> ready);
endmodule

// File: tb/test_sp_pin_ctrl.sv
module test_sp_pin_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] clk_dir = '0, clk_pol = '0, fs_dir = '0, fs_pol = '0;
  logic [1:0] clk_pin = '0, fs_pin = '0, gen_fs = '0;
  logic       gen_clk = 1'b0;
  logic [1:0] clk_pin_o, clk_oe_o, fs_pin_o, fs_oe_o, rise_en, fall_en, fs_int;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sp_pin_ctrl i_sp_pin_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .clk_dir_i(clk_dir), .clk_pol_i(clk_pol), .fs_dir_i(fs_dir), .fs_pol_i(fs_pol),
    .clk_pin_i(clk_pin), .fs_pin_i(fs_pin), .gen_clk_i(gen_clk), .gen_fs_i(gen_fs),
    .clk_pin_o(clk_pin_o), .clk_oe_o(clk_oe_o), .fs_pin_o(fs_pin_o), .fs_oe_o(fs_oe_o),
    .rise_en_o(rise_en), .fall_en_o(fall_en), .fs_int_o(fs_int)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  initial begin
    // R7: hold reset with a pin that settles high after reset
    clk_pin = 2'b11;
    tick(3);
    chk("R7 rise after reset", rise_en[0], 1'b0);
    chk("R7 fs_int after reset", fs_int[1], 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R7 warm-up rise quiet", |rise_en, 1'b0);
      chk("R7 warm-up fall quiet", |fall_en, 1'b0);
    end

    for (int ch = 0; ch < 2; ch++) begin
      for (int p = 0; p < 2; p++) begin
        // R1/R3/R4: input clock
        clk_dir[ch] = 1'b0; fs_dir[ch] = 1'b0;
        clk_pol[ch] = p[0]; clk_pin[ch] = 1'b0;
        tick(5);
        chk("R1 clk oe input", clk_oe_o[ch], 1'b0);
        chk("R1 fs oe input", fs_oe_o[ch], 1'b0);
        for (int v = 1; v >= 0; v--) begin
          clk_pin[ch] = v[0];
          tick();
          chk("R3 no early edge", rise_en[ch] | fall_en[ch], 1'b0);
          tick();
          chk("R3 rise at latency", rise_en[ch], v[0] ^ p[0]);
          chk("R3 fall at latency", fall_en[ch], ~(v[0] ^ p[0]));
          tick();
          chk("R4 single-cycle rise", rise_en[ch], 1'b0);
          chk("R4 single-cycle fall", fall_en[ch], 1'b0);
        end

        // R5: external frame-sync, clock input with polarity 0
        clk_pol[ch] = 1'b0; fs_pol[ch] = p[0];
        for (int f = 0; f < 2; f++) begin
          logic hold;
          clk_pin[ch] = 1'b0; tick(4);
          fs_pin[ch] = f[0]; tick(4);
          hold = fs_int[ch];
          clk_pin[ch] = 1'b1; tick(3);
          chk("R5 rising edge ignored", fs_int[ch], hold);
          clk_pin[ch] = 1'b0; tick(2);
          chk("R5 fall enable seen", fall_en[ch], 1'b1);
          chk("R5 not yet captured", fs_int[ch], hold);
          tick();
          chk("R5 captured on fall", fs_int[ch], f[0] ^ p[0]);
        end

        // R2/R6: output clock and frame-sync
        clk_dir[ch] = 1'b1; fs_dir[ch] = 1'b1;
        clk_pol[ch] = p[0]; fs_pol[ch] = p[0];
        chk("R1 clk oe output", clk_oe_o[ch], 1'b1);
        chk("R1 fs oe output", fs_oe_o[ch], 1'b1);
        for (int g = 1; g >= 0; g--) begin
          logic hold;
          gen_clk = 1'b0; tick(2);
          chk("R2 pin low level", clk_pin_o[ch], p[0]);
          hold = fs_pin_o[ch];
          gen_fs[ch] = g[0]; tick();
          chk("R6 gen_fs ignored between edges", fs_pin_o[ch], hold);
          gen_clk = 1'b1; #1;
          chk("R2 pin high level", clk_pin_o[ch], ~p[0]);
          chk("R4 rise on generated clock", rise_en[ch], 1'b1);
          tick();
          chk("R4 rise ends", rise_en[ch], 1'b0);
          chk("R6 fs_int registered", fs_int[ch], g[0]);
          chk("R6 fs pin polarity", fs_pin_o[ch], g[0] ^ p[0]);
          gen_clk = 1'b0; #1;
          chk("R4 fall on generated clock", fall_en[ch], 1'b1);
          tick();
        end
        clk_dir[ch] = 1'b0; fs_dir[ch] = 1'b0; gen_fs[ch] = 1'b0;
        clk_pin[ch] = 1'b0; clk_pol[ch] = 1'b0; fs_pol[ch] = 1'b0;
        tick(5);
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule